// File: doc/BRIEF.md
# Command Slot Scanner and Register-FIS Decoder

This block serves one port of a storage host controller. Software marks command slots as issued. While the port's run enable is high and the attached command engine is idle, the block selects the lowest-numbered issued slot and shows its index on `sel_slot`. The 20-byte host-to-device register FIS of that slot arrives in the same cycle on `fis_bytes`, with byte k in bits 8k+7:8k. The block checks the FIS header and follows the soft-reset control bit from one FIS to the next. It classifies the command as queued or legacy and extracts the command byte, feature, sector count, LBA and queue tag. The decoded fields leave on a registered one-cycle valid strobe.

Queued commands claim a tag in an in-use vector. A completion input frees the tag again. A legacy command keeps its slot until the engine reports that it is not busy. Fetching the FIS from memory and executing the command are done by neighbouring logic.

Top module: `cmd_slot_decoder`

## Requirements
- R1: After reset, `issue_vec`, `tags_busy`, `dec_valid`, `tag_accept` and `port_reset` are all zero, and the soft-reset tracker is in its run state.
- R2: A cycle with `issue_set_valid` high ORs `issue_set_mask` into `issue_vec` at the next edge. Bits already set stay set.
- R3: A slot is taken only while `run_en` is high, and then the lowest-numbered set bit of `issue_vec` goes first. At most one slot is taken per cycle, and none is taken while `run_en` is low.
- R4: A FIS is accepted only if byte 0 equals 0x27 and byte 1 is either 0x00 or has bit 7 set. Any other FIS retires its slot at the next edge. It produces no `dec_valid` and leaves the soft-reset tracker unchanged.
- R5: With byte 1 bit 7 set, command byte (byte 2) 0x60 or 0x61 is queued, and 0x61 is the write. For a queued command, the tag is byte 12 bits 7:3. The LBA is bytes 10,9,8,6,5,4, most significant first. The count is byte 11 over byte 3. The slot is retired at the next edge.
- R6: With byte 1 bit 7 set and any other command byte, the command is legacy. The feature is byte 3. The count is byte 13 over byte 12, and a count of 0 reads as 256. The LBA is {byte10, byte9, byte8 OR byte7[3:0], byte6, byte5, byte4}.
- R7: A legacy slot stays issued after its decode. It is retired on the first later edge at which `eng_busy` is low, and no other slot is taken before then.
- R8: While `eng_busy` is high, no slot is taken.
- R9: A queued command whose tag is free sets that bit of `tags_busy` and pulses `tag_accept` along with `dec_valid`. A queued command whose tag is already in use is dropped: there is no strobe, but its slot is still retired.
- R10: `tag_done_valid` clears bit `tag_done_id` of `tags_busy` at the next edge.
- R11: The soft-reset bit is byte 15 bit 2. In the run state, an accepted FIS with the bit set moves the tracker to the reset state. In the reset state, an accepted FIS with the bit clear pulses `port_reset` for one cycle, clears `tags_busy` and returns the tracker to run.
- R12: A FIS with byte 1 equal to 0x00 produces no decode. It retires its slot at the next edge and takes part only in soft-reset tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Port run enable; allows slot selection |
| issue_set_valid | input | 1 | Issue write strobe |
| issue_set_mask | input | SLOTS | Slots to mark as issued |
| eng_busy | input | 1 | Engine busy or data-request |
| fis_bytes | input | 8*FIS_BYTES | FIS of the slot on `sel_slot`, byte k at bits 8k+7:8k |
| tag_done_valid | input | 1 | Queued completion strobe |
| tag_done_id | input | log2(SLOTS) | Tag being completed |
| issue_vec | output | SLOTS | Issued slots still pending |
| sel_valid | output | 1 | A slot is taken this cycle |
| sel_slot | output | log2(SLOTS) | Slot whose FIS must be on `fis_bytes` |
| dec_valid | output | 1 | Decoded command strobe |
| dec_slot | output | log2(SLOTS) | Slot of the decoded command |
| dec_queued | output | 1 | Decoded command is queued |
| dec_write | output | 1 | Queued write |
| dec_cmd | output | 8 | Command byte |
| dec_feature | output | 8 | Feature byte |
| dec_count | output | 16 | Sector count |
| dec_lba | output | 48 | Logical block address |
| dec_tag | output | log2(SLOTS) | Queue tag |
| tag_accept | output | 1 | Queued tag claimed |
| tags_busy | output | SLOTS | Tags in use |
| port_reset | output | 1 | Soft-reset release pulse |

## Verification
Some properties are checked by assertions on every cycle. A held legacy slot keeps its index while the engine is busy. No strobe follows a cycle with the engine busy or the port stopped. A newly issued mask is present in the pending vector. An accepted tag is marked in use, and a reset pulse is never longer than one cycle and leaves the tag vector empty. Other behaviour can only be shown by the directed scenarios, because it depends on the FIS contents and on history. These are the low-to-high slot order, the field extraction of both formats, the 0-means-256 count, the OR of the two LBA nibbles, dropping a conflicting tag, and the two-FIS soft-reset sequence, including the way aborted FISes leave the tracker untouched.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

   localparam logic [7:0] FIS_TYPE_H2D = 8'h27;
   localparam logic [7:0] CMD_Q_READ   = 8'h60;
   localparam logic [7:0] CMD_Q_WRITE  = 8'h61;
   localparam int         UPD_BIT      = 7;
   localparam int         SRST_BIT     = 2;
   localparam int         SRST_BYTE    = 15;
   localparam int         LBA_W        = 48;
   localparam int         CNT_W        = 16;

   typedef enum logic {TRK_RUN = 1'b0, TRK_RESET = 1'b1} trk_state_e;

   typedef struct packed {
      logic             queued;
      logic             is_write;
      logic [7:0]       cmd;
      logic [7:0]       feature;
      logic [CNT_W-1:0] count;
      logic [LBA_W-1:0] lba;
      logic [4:0]       tag;
   } fis_fields_t;

endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
   parameter int N = 32,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] req,
   output logic         found,
   output logic [W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = W'(i);
         end
      end
   end
endmodule

// File: rtl/fis_decode.sv
module fis_decode
   import cmd_dec_pkg::*;
#(
   parameter int FIS_BYTES = 20
) (
   input  logic [FIS_BYTES*8-1:0] fis,
   output logic                   hdr_ok,
   output logic                   upd,
   output logic                   srst,
   output fis_fields_t            f
);
   logic [7:0] b [FIS_BYTES];

   for (genvar k = 0; k < FIS_BYTES; k++) begin : g_byte
      assign b[k] = fis[8*k +: 8];
   end

   logic [15:0] raw_cnt;

   always_comb begin
      hdr_ok = (b[0] == FIS_TYPE_H2D) && ((b[1] == 8'h00) || b[1][UPD_BIT]);
      upd    = b[1][UPD_BIT];
      srst   = b[SRST_BYTE][SRST_BIT];

      f          = '0;
      f.cmd      = b[2];
      f.feature  = b[3];
      f.tag      = b[12][7:3];
      f.queued   = (b[2] == CMD_Q_READ) || (b[2] == CMD_Q_WRITE);
      f.is_write = (b[2] == CMD_Q_WRITE);
      raw_cnt    = {b[13], b[12]};
      if (f.queued) begin
         f.count = {b[11], b[3]};
         f.lba   = {b[10], b[9], b[8], b[6], b[5], b[4]};
      end else begin
         f.count = (raw_cnt == 16'd0) ? 16'd256 : raw_cnt;
         f.lba   = {b[10], b[9], b[8] | {4'h0, b[7][3:0]}, b[6], b[5], b[4]};
      end
   end
endmodule

// File: rtl/srst_track.sv
module srst_track
   import cmd_dec_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic srst,
   output logic fire
);
   trk_state_e state_q;

   assign fire = evt && (state_q == TRK_RESET) && !srst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TRK_RUN;
      end else if (evt) begin
         if (state_q == TRK_RUN && srst)
            state_q <= TRK_RESET;
         else if (state_q == TRK_RESET && !srst)
            state_q <= TRK_RUN;
      end
   end
endmodule

// File: rtl/tag_table.sv
module tag_table #(
   parameter int N = 32,
   localparam int W = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic         acc_valid,
   input  logic [W-1:0] acc_tag,
   input  logic         done_valid,
   input  logic [W-1:0] done_tag,
   output logic [N-1:0] busy
);
   for (genvar i = 0; i < N; i++) begin : g_tag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            busy[i] <= 1'b0;
         else if (acc_valid && acc_tag == W'(i))
            busy[i] <= 1'b1;
         else if (clr_all || (done_valid && done_tag == W'(i)))
            busy[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/cmd_slot_decoder.sv
module cmd_slot_decoder
   import cmd_dec_pkg::*;
#(
   parameter int SLOTS     = 32,
   parameter int FIS_BYTES = 20,
   localparam int SLOT_W   = $clog2(SLOTS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run_en,
   input  logic                   issue_set_valid,
   input  logic [SLOTS-1:0]       issue_set_mask,
   input  logic                   eng_busy,
   input  logic [FIS_BYTES*8-1:0] fis_bytes,
   input  logic                   tag_done_valid,
   input  logic [SLOT_W-1:0]      tag_done_id,
   output logic [SLOTS-1:0]       issue_vec,
   output logic                   sel_valid,
   output logic [SLOT_W-1:0]      sel_slot,
   output logic                   dec_valid,
   output logic [SLOT_W-1:0]      dec_slot,
   output logic                   dec_queued,
   output logic                   dec_write,
   output logic [7:0]             dec_cmd,
   output logic [7:0]             dec_feature,
   output logic [CNT_W-1:0]       dec_count,
   output logic [LBA_W-1:0]       dec_lba,
   output logic [SLOT_W-1:0]      dec_tag,
   output logic                   tag_accept,
   output logic [SLOTS-1:0]       tags_busy,
   output logic                   port_reset
);
   if (SLOTS < 2 || SLOTS > 32 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two between 2 and 32");
   end
   if (FIS_BYTES < SRST_BYTE + 1) begin : g_bad_fis
      $error("FIS_BYTES too small for the control byte");
   end

   logic [SLOTS-1:0]  issue_q;
   logic              wait_q;
   logic [SLOT_W-1:0] wait_slot_q;
   logic              pick_found;
   logic [SLOT_W-1:0] pick_idx;
   logic              hdr_ok, upd, srst, trk_fire;
   fis_fields_t       fld;

   slot_pick #(.N(SLOTS)) u_pick (
      .req   (issue_q),
      .found (pick_found),
      .idx   (pick_idx)
   );

   fis_decode #(.FIS_BYTES(FIS_BYTES)) u_dec (
      .fis    (fis_bytes),
      .hdr_ok (hdr_ok),
      .upd    (upd),
      .srst   (srst),
      .f      (fld)
   );

   logic take, fis_ok, is_q, is_legacy, acc, retire_now, retire_wait;
   logic [SLOT_W-1:0] q_tag;
   logic [SLOTS-1:0]  clr_mask;

   assign take        = run_en && !eng_busy && !wait_q && pick_found;
   assign fis_ok      = take && hdr_ok;
   assign q_tag       = fld.tag[SLOT_W-1:0];
   assign is_q        = fis_ok && upd && fld.queued;
   assign is_legacy   = fis_ok && upd && !fld.queued;
   assign acc         = is_q && (!tags_busy[q_tag] || trk_fire);
   assign retire_now  = take && !is_legacy;
   assign retire_wait = wait_q && !eng_busy;

   srst_track u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (fis_ok),
      .srst  (srst),
      .fire  (trk_fire)
   );

   tag_table #(.N(SLOTS)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_all    (trk_fire),
      .acc_valid  (acc),
      .acc_tag    (q_tag),
      .done_valid (tag_done_valid),
      .done_tag   (tag_done_id),
      .busy       (tags_busy)
   );

   always_comb begin
      clr_mask = '0;
      if (retire_now)  clr_mask[pick_idx]    = 1'b1;
      if (retire_wait) clr_mask[wait_slot_q] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue_q     <= '0;
         wait_q      <= 1'b0;
         wait_slot_q <= '0;
      end else begin
         issue_q <= (issue_q & ~clr_mask) | (issue_set_valid ? issue_set_mask : '0);
         if (is_legacy) begin
            wait_q      <= 1'b1;
            wait_slot_q <= pick_idx;
         end else if (retire_wait) begin
            wait_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid   <= 1'b0;
         dec_slot    <= '0;
         dec_queued  <= 1'b0;
         dec_write   <= 1'b0;
         dec_cmd     <= '0;
         dec_feature <= '0;
         dec_count   <= '0;
         dec_lba     <= '0;
         dec_tag     <= '0;
         tag_accept  <= 1'b0;
         port_reset  <= 1'b0;
      end else begin
         dec_valid  <= is_legacy || acc;
         tag_accept <= acc;
         port_reset <= trk_fire;
         if (is_legacy || acc) begin
            dec_slot    <= pick_idx;
            dec_queued  <= fld.queued;
            dec_write   <= fld.is_write;
            dec_cmd     <= fld.cmd;
            dec_feature <= fld.feature;
            dec_count   <= fld.count;
            dec_lba     <= fld.lba;
            dec_tag     <= q_tag;
         end
      end
   end

   assign issue_vec = issue_q;
   assign sel_valid = take;
   assign sel_slot  = pick_idx;

   AST_ISSUE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      issue_set_valid |=> ((issue_q & $past(issue_set_mask)) == $past(issue_set_mask))); // R2
   AST_NO_STROBE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en || eng_busy) |=> !dec_valid); // R3
   AST_BUSY_HOLDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q && eng_busy) |=> (wait_q && $stable(wait_slot_q) && issue_q[wait_slot_q])); // R7
   AST_TAG_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      tag_accept |-> (dec_valid && dec_queued && tags_busy[dec_tag])); // R9
   AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      port_reset |=> !port_reset); // R11
   AST_RESET_CLEARS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (port_reset && !tag_accept) |-> (tags_busy == '0)); // R11
endmodule

// File: tb/cmd_slot_decoder_bench.sv
module cmd_slot_decoder_bench;
   localparam int SLOTS = 32;
   localparam int FB    = 20;
   localparam int SW    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 1'b0;
   logic issue_set_valid = 1'b0;
   logic [SLOTS-1:0] issue_set_mask = '0;
   logic eng_busy = 1'b0;
   logic [FB*8-1:0] fis_bytes;
   logic tag_done_valid = 1'b0;
   logic [SW-1:0] tag_done_id = '0;
   logic [SLOTS-1:0] issue_vec, tags_busy;
   logic sel_valid, dec_valid, dec_queued, dec_write, tag_accept, port_reset;
   logic [SW-1:0] sel_slot, dec_slot, dec_tag;
   logic [7:0] dec_cmd, dec_feature;
   logic [15:0] dec_count;
   logic [47:0] dec_lba;

   logic [FB*8-1:0] fis_mem [SLOTS];
   always_comb fis_bytes = fis_mem[sel_slot];

   always #4 clk = ~clk;

   cmd_slot_decoder u_cmd_slot_decoder (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .issue_set_valid(issue_set_valid), .issue_set_mask(issue_set_mask),
      .eng_busy(eng_busy), .fis_bytes(fis_bytes),
      .tag_done_valid(tag_done_valid), .tag_done_id(tag_done_id),
      .issue_vec(issue_vec), .sel_valid(sel_valid), .sel_slot(sel_slot),
      .dec_valid(dec_valid), .dec_slot(dec_slot), .dec_queued(dec_queued),
      .dec_write(dec_write), .dec_cmd(dec_cmd), .dec_feature(dec_feature),
      .dec_count(dec_count), .dec_lba(dec_lba), .dec_tag(dec_tag),
      .tag_accept(tag_accept), .tags_busy(tags_busy), .port_reset(port_reset)
   );

   int n_chk = 0;
   int n_fail = 0;
   int n_dec = 0;
   int n_acc = 0;
   int n_prst = 0;
   logic [SW-1:0] log_slot [64];
   logic [SW-1:0] last_tag;
   logic last_q, last_w;
   logic [7:0] last_cmd, last_feat;
   logic [15:0] last_cnt;
   logic [47:0] last_lba;

   always @(negedge clk) begin
      if (rst_n) begin
         if (dec_valid) begin
            log_slot[n_dec % 64] = dec_slot;
            last_tag = dec_tag; last_q = dec_queued; last_w = dec_write;
            last_cmd = dec_cmd; last_feat = dec_feature;
            last_cnt = dec_count; last_lba = dec_lba;
            n_dec++;
         end
         if (tag_accept) n_acc++;
         if (port_reset) n_prst++;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic put(input int s, input int k, input logic [7:0] v);
      fis_mem[s][8*k +: 8] = v;
   endtask

   task automatic mk_raw(input int s, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b15);
      fis_mem[s] = '0;
      put(s, 0, b0); put(s, 1, b1); put(s, 15, b15);
   endtask

   task automatic mk_legacy(input int s, input logic [7:0] cmd, input logic [7:0] feat,
                            input logic [47:0] lba, input logic [7:0] b7, input logic [15:0] cnt);
      mk_raw(s, 8'h27, 8'h80, 8'h00);
      put(s, 2, cmd); put(s, 3, feat);
      put(s, 4, lba[7:0]); put(s, 5, lba[15:8]); put(s, 6, lba[23:16]);
      put(s, 7, b7); put(s, 8, lba[31:24]); put(s, 9, lba[39:32]); put(s, 10, lba[47:40]);
      put(s, 12, cnt[7:0]); put(s, 13, cnt[15:8]);
   endtask

   task automatic mk_queued(input int s, input logic wr, input logic [4:0] tag,
                            input logic [47:0] lba, input logic [15:0] cnt);
      mk_raw(s, 8'h27, 8'h80, 8'h00);
      put(s, 2, wr ? 8'h61 : 8'h60); put(s, 3, cnt[7:0]); put(s, 11, cnt[15:8]);
      put(s, 4, lba[7:0]); put(s, 5, lba[15:8]); put(s, 6, lba[23:16]);
      put(s, 7, 8'h40); put(s, 8, lba[31:24]); put(s, 9, lba[39:32]); put(s, 10, lba[47:40]);
      put(s, 12, {tag, 3'b000});
   endtask

   task automatic issue(input logic [SLOTS-1:0] m);
      @(negedge clk);
      issue_set_valid = 1'b1; issue_set_mask = m;
      @(negedge clk);
      issue_set_valid = 1'b0; issue_set_mask = '0;
   endtask

   task automatic t_reset;
      chk("R1", "issue_vec", 64'(issue_vec), 0);
      chk("R1", "tags_busy", 64'(tags_busy), 0);
      chk("R1", "strobes", {61'd0, dec_valid, tag_accept, port_reset}, 0);
   endtask

   task automatic t_legacy;
      int d0 = n_dec;
      mk_legacy(3, 8'h25, 8'h5A, 48'h665544332211, 8'hE0, 16'h0110);
      issue(32'h8);
      idle(5);
      chk("R6", "decode count", n_dec - d0, 1);
      chk("R6", "slot", 64'(log_slot[d0 % 64]), 3);
      chk("R6", "queued", 64'(last_q), 0);
      chk("R6", "cmd/feat", {last_cmd, last_feat}, 16'h255A);
      chk("R6", "count", 64'(last_cnt), 16'h0110);
      chk("R6", "lba", 64'(last_lba), 48'h665544332211);
      chk("R7", "slot retired when idle", 64'(issue_vec), 0);
   endtask

   task automatic t_zero_count;
      mk_legacy(0, 8'h35, 8'h00, 48'h000005000000, 8'hA3, 16'h0000);
      issue(32'h1);
      idle(5);
      chk("R6", "zero count reads 256", 64'(last_cnt), 256);
      chk("R6", "lba nibble OR", 64'(last_lba), 48'h000007000000);
   endtask

   task automatic t_order;
      int d0 = n_dec;
      int a0 = n_acc;
      mk_queued(5, 1'b1, 5'd4, 48'hABCDEF012345, 16'h0208);
      mk_queued(1, 1'b0, 5'd2, 48'h1, 16'h0001);
      mk_queued(9, 1'b0, 5'd6, 48'h2, 16'h0002);
      issue(32'h222);
      idle(6);
      chk("R3", "first slot", 64'(log_slot[d0 % 64]), 1);
      chk("R3", "second slot", 64'(log_slot[(d0 + 1) % 64]), 5);
      chk("R3", "third slot", 64'(log_slot[(d0 + 2) % 64]), 9);
      chk("R9", "accept pulses", n_acc - a0, 3);
      chk("R9", "tags in use", 64'(tags_busy), 32'h54);
      chk("R5", "queued slots retired", 64'(issue_vec), 0);
   endtask

   task automatic t_queued_fields;
      mk_queued(17, 1'b1, 5'd20, 48'h0A0B0C0D0E0F, 16'h1234);
      issue(32'h1 << 17);
      idle(5);
      chk("R5", "queued/write", {last_q, last_w}, 2'b11);
      chk("R5", "tag", 64'(last_tag), 20);
      chk("R5", "lba", 64'(last_lba), 48'h0A0B0C0D0E0F);
      chk("R5", "count", 64'(last_cnt), 16'h1234);
      @(negedge clk); tag_done_valid = 1'b1; tag_done_id = 5'd20;
      @(negedge clk); tag_done_valid = 1'b0;
   endtask

   task automatic t_tag_conflict;
      int d0 = n_dec;
      mk_queued(2, 1'b0, 5'd4, 48'h9, 16'h0009);
      issue(32'h4);
      idle(5);
      chk("R9", "busy tag dropped", n_dec - d0, 0);
      chk("R9", "dropped slot retired", 64'(issue_vec), 0);
      @(negedge clk); tag_done_valid = 1'b1; tag_done_id = 5'd4;
      @(negedge clk); tag_done_valid = 1'b0;
      idle(1);
      chk("R10", "tag freed", 64'(tags_busy), 32'h44);
   endtask

   task automatic t_run_off;
      int d0 = n_dec;
      run_en = 1'b0;
      mk_legacy(4, 8'hC8, 8'h00, 48'h10, 8'h00, 16'h0008);
      issue(32'h10);
      idle(5);
      chk("R3", "no take while stopped", n_dec - d0, 0);
      chk("R3", "slot still pending", 64'(issue_vec), 32'h10);
      run_en = 1'b1;
      idle(5);
      chk("R3", "taken after start", n_dec - d0, 1);
      chk("R3", "slot retired", 64'(issue_vec), 0);
   endtask

   task automatic t_eng_busy;
      int d0 = n_dec;
      eng_busy = 1'b1;
      mk_queued(8, 1'b0, 5'd10, 48'h3, 16'h0003);
      issue(32'h100);
      idle(5);
      chk("R8", "no take while busy", n_dec - d0, 0);
      chk("R8", "slot pending", 64'(issue_vec), 32'h100);
      eng_busy = 1'b0;
      idle(5);
      chk("R8", "taken after idle", n_dec - d0, 1);
   endtask

   task automatic t_legacy_hold;
      int d0 = n_dec;
      mk_legacy(6, 8'hCA, 8'h00, 48'h20, 8'h00, 16'h0004);
      mk_queued(7, 1'b0, 5'd12, 48'h4, 16'h0004);
      issue(32'hC0);
      for (int i = 0; i < 20 && !dec_valid; i++) @(negedge clk);
      eng_busy = 1'b1;
      idle(4);
      chk("R7", "only legacy decoded", n_dec - d0, 1);
      chk("R7", "both slots held", 64'(issue_vec), 32'hC0);
      eng_busy = 1'b0;
      idle(5);
      chk("R7", "queued follows", n_dec - d0, 2);
      chk("R7", "slot order", 64'(log_slot[(d0 + 1) % 64]), 7);
      chk("R7", "all retired", 64'(issue_vec), 0);
   endtask

   task automatic t_abort;
      int d0 = n_dec;
      int p0 = n_prst;
      mk_raw(12, 8'h34, 8'h80, 8'h04);
      mk_raw(13, 8'h27, 8'h05, 8'h04);
      mk_raw(14, 8'h27, 8'h00, 8'h00);
      issue(32'h7000);
      idle(6);
      chk("R4", "no decode on bad header", n_dec - d0, 0);
      chk("R4", "tracker untouched", n_prst - p0, 0);
      chk("R4", "slots retired", 64'(issue_vec), 0);
   endtask

   task automatic t_soft_reset;
      int d0 = n_dec;
      int p0 = n_prst;
      mk_raw(10, 8'h27, 8'h00, 8'h04);
      mk_raw(11, 8'h27, 8'h00, 8'h00);
      issue(32'hC00);
      idle(6);
      chk("R12", "no decode for update-clear FIS", n_dec - d0, 0);
      chk("R12", "slots retired", 64'(issue_vec), 0);
      chk("R11", "one reset pulse", n_prst - p0, 1);
      chk("R11", "tags cleared", 64'(tags_busy), 0);
   endtask

   initial begin
      for (int s = 0; s < SLOTS; s++) fis_mem[s] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      idle(1);
      t_reset();
      run_en = 1'b1;
      t_legacy();
      t_zero_count();
      t_order();
      t_queued_fields();
      t_tag_conflict();
      t_run_off();
      t_eng_busy();
      t_legacy_hold();
      t_abort();
      t_soft_reset();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule